// File: doc/BRIEF.md
# Power-On Strap Latch and Pin Turnaround Controller

This block owns a group of dual-purpose pad pins. Straight after reset each pin is used as an input: its output driver is turned off so an external strapping resistor can set the level on the pad. A power-on timer counts reference clock cycles. While it counts, the pins stay in input mode. When the timer expires, the block latches the pad levels into a configuration register. On the same edge it turns every pin around to drive its clock.

Six pins are handled. Five of them carry the frequency-select bits that choose the operating frequency mode. The sixth chooses the rate of the shared low-speed clock output. The clock sources come in as plain input signals. Once the pins are driving, each source goes straight to its pad through a per-pin gating mask, with no glitch suppression. This means the first output period may be short. A done flag tells downstream logic that the latched configuration is valid.

The block has two states. `ST_HOLD` is entered on reset: the drivers are tri-stated, the timer runs and the configuration register is held at zero. The transition to `ST_DRIVE` is taken on the edge where the timer expires; the straps are latched on that same edge. `ST_DRIVE` enables all drivers and raises the done flag. It has no exit except reset.

Top module: `strap_turnaround_ctl`

## Requirements
- R1: While reset is asserted, and straight after it is released, `pad_oe` is all zeros, `pad_out` is all zeros, `cfg_done` is 0, `freq_sel` is 0 and `rate_sel` is 0.
- R2: `cfg_done` rises and `pad_oe` becomes all ones exactly WAIT_CYCLES rising edges of `clk_ref` after reset is released. Before that, `pad_oe` stays all zeros and `cfg_done` stays 0.
- R3: The value captured is the one `pad_in` holds at the edge that enables the outputs: `freq_sel[k]` = `pad_in[k]` for k = 0..4, and `rate_sel` = `pad_in[5]` (1 selects 48 MHz, 0 selects 24 MHz). Values that `pad_in` held at earlier edges have no effect.
- R4: Once `cfg_done` is 1, changes on `pad_in` have no effect on `freq_sel` or `rate_sel` until the next reset.
- R5: Once `cfg_done` is 1, it stays 1 and `pad_oe` stays all ones until reset.
- R6: In the driving state, `pad_out[i]` equals `clk_src[i]` when `oe_mask[i]` is 1 and is 0 when `oe_mask[i]` is 0. The path is combinational, so the source appears in the same cycle with no glitch filtering. In the hold state `pad_out` is all zeros.
- R7: An asynchronous reset asserted partway through the hold interval restarts the timer. After that reset is released, a full WAIT_CYCLES edges are needed again before the outputs are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock for the timer and the strap register |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_in | input | 6 | Pad input levels; [4:0] frequency select, [5] rate select |
| clk_src | input | 6 | Clock sources forwarded to each pad |
| oe_mask | input | 6 | Per-pin gate; 0 holds that pad output low |
| pad_out | output | 6 | Pad output data |
| pad_oe | output | 6 | Pad driver enable, 1 = driving |
| freq_sel | output | 5 | Latched frequency-select strap |
| rate_sel | output | 1 | Latched low-speed rate strap |
| cfg_done | output | 1 | Configuration valid and outputs driven |

## Verification
Some properties are checked on every cycle. The drivers stay off and the configuration register stays cleared while done is low. The done flag stays high once set, and the latched straps do not move. The masked pads stay low. The capture matches the pad value from the preceding edge. A cycle counter in the checker confirms that done rises after exactly the programmed number of edges.

Other behaviour can only be shown by the bench's scenarios. These cover pad values that change during the window but before the capture edge, strap changes after done, random source and mask patterns, and a reset that cuts the window short and restarts the count.

// File: rtl/strap_pkg.sv
package strap_pkg;
    localparam int unsigned FS_BITS   = 5;
    localparam int unsigned PIN_COUNT = FS_BITS + 1;

    typedef enum logic [0:0] {
        ST_HOLD  = 1'b0,
        ST_DRIVE = 1'b1
    } boot_state_e;

    typedef struct packed {
        logic               rate;
        logic [FS_BITS-1:0] fs;
    } strap_cfg_t;
endpackage

// File: rtl/por_timer.sv
module por_timer #(
    parameter int unsigned WAIT_CYCLES = 28636
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int unsigned CNT_W = (WAIT_CYCLES < 2) ? 1 : $clog2(WAIT_CYCLES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

    logic [CNT_W-1:0] count_q;

    assign expire = run && (count_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run && !expire) begin
            count_q <= count_q + 1'b1;
        end
    end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic [PIN_COUNT-1:0] pins,
    output strap_cfg_t           cfg
);
    strap_cfg_t cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= strap_cfg_t'(pins);
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pad_turn.sv
module pad_turn #(
    parameter int unsigned PINS = 6
) (
    input  logic            drive,
    input  logic [PINS-1:0] clk_src,
    input  logic [PINS-1:0] mask,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        assign pad_oe[i]  = drive;
        assign pad_out[i] = drive & mask[i] & clk_src[i];
    end
endmodule

// File: rtl/strap_turnaround_ctl.sv
module strap_turnaround_ctl
    import strap_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 28636
) (
    input  logic                 clk_ref,
    input  logic                 rst_n,
    input  logic [PIN_COUNT-1:0] pad_in,
    input  logic [PIN_COUNT-1:0] clk_src,
    input  logic [PIN_COUNT-1:0] oe_mask,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [FS_BITS-1:0]   freq_sel,
    output logic                 rate_sel,
    output logic                 cfg_done
);
    boot_state_e state_q, state_d;
    logic        timer_run;
    logic        timer_expire;
    logic        drive_en;
    strap_cfg_t  cfg;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HOLD:  if (timer_expire) state_d = ST_DRIVE;
            ST_DRIVE: state_d = ST_DRIVE;
            default:  state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        timer_run = 1'b0;
        drive_en  = 1'b0;
        unique case (state_q)
            ST_HOLD:  timer_run = 1'b1;
            ST_DRIVE: drive_en  = 1'b1;
            default:  ;
        endcase
    end

    por_timer #(.WAIT_CYCLES(WAIT_CYCLES)) timer_i (
        .clk    (clk_ref),
        .rst_n  (rst_n),
        .run    (timer_run),
        .expire (timer_expire)
    );

    strap_capture cap_i (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .load  (timer_expire),
        .pins  (pad_in),
        .cfg   (cfg)
    );

    pad_turn #(.PINS(PIN_COUNT)) pads_i (
        .drive   (drive_en),
        .clk_src (clk_src),
        .mask    (oe_mask),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign freq_sel = cfg.fs;
    assign rate_sel = cfg.rate;
    assign cfg_done = drive_en;
endmodule

// File: rtl/strap_turnaround_chk.sv
module strap_turnaround_chk
    import strap_pkg::*;
#(
    parameter int unsigned WAIT_CYCLES = 28636
) (
    input logic                 clk_ref,
    input logic                 rst_n,
    input logic [PIN_COUNT-1:0] pad_in,
    input logic [PIN_COUNT-1:0] oe_mask,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [FS_BITS-1:0]   freq_sel,
    input logic                 rate_sel,
    input logic                 cfg_done
);
    logic [31:0] hold_cyc;

    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n)         hold_cyc <= '0;
        else if (!cfg_done) hold_cyc <= hold_cyc + 1'b1;
    end

    // R1, R2: drivers off and register clear until done
    a_r1_hiz_while_hold: assert property (@(posedge clk_ref) disable iff (!rst_n)
        !cfg_done |-> (pad_oe == '0) && (freq_sel == '0) && !rate_sel);

    // R2, R7: done rises after exactly WAIT_CYCLES edges since reset
    a_r2_interval: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(cfg_done) |-> (hold_cyc == WAIT_CYCLES));

    // R3: capture equals pad levels at the enabling edge
    a_r3_capture: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $rose(cfg_done) |-> ({rate_sel, freq_sel} == $past(pad_in)));

    // R4: latched value frozen after done
    a_r4_frozen: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_done |=> $stable(freq_sel) && $stable(rate_sel));

    // R5: done sticky, all drivers on
    a_r5_sticky: assert property (@(posedge clk_ref) disable iff (!rst_n)
        cfg_done |=> cfg_done && (pad_oe == '1));

    // R6: masked or idle pads stay low
    a_r6_gate: assert property (@(posedge clk_ref) disable iff (!rst_n)
        ((pad_out & ~oe_mask) == '0) && (cfg_done || pad_out == '0));
endmodule

bind strap_turnaround_ctl strap_turnaround_chk #(.WAIT_CYCLES(WAIT_CYCLES)) chk_i (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .pad_in   (pad_in),
    .oe_mask  (oe_mask),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .freq_sel (freq_sel),
    .rate_sel (rate_sel),
    .cfg_done (cfg_done)
);

// File: tb/strap_turnaround_ctl_tb_top.sv
module strap_turnaround_ctl_tb_top;
    localparam int unsigned WAIT = 37;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [5:0] pad_in  = '0;
    logic [5:0] clk_src = '0;
    logic [5:0] oe_mask = '0;
    logic [5:0] pad_out, pad_oe;
    logic [4:0] freq_sel;
    logic       rate_sel, cfg_done;

    int n_cmp = 0;
    int n_bad = 0;
    bit ended = 0;

    always #10 clk_ref = ~clk_ref;

    strap_turnaround_ctl #(.WAIT_CYCLES(WAIT)) dut_i (
        .clk_ref(clk_ref), .rst_n(rst_n), .pad_in(pad_in), .clk_src(clk_src),
        .oe_mask(oe_mask), .pad_out(pad_out), .pad_oe(pad_oe),
        .freq_sel(freq_sel), .rate_sel(rate_sel), .cfg_done(cfg_done)
    );

    function automatic logic [5:0] exp_out(input logic on, input logic [5:0] s, input logic [5:0] m);
        return on ? (s & m) : 6'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    task automatic check_hold(input string req);
        check({req, " oe"},   32'(pad_oe),   32'h0);
        check({req, " out"},  32'(pad_out),  32'h0);
        check({req, " done"}, 32'(cfg_done), 32'h0);
        check({req, " cfg"},  32'({rate_sel, freq_sel}), 32'h0);
    endtask

    // reset at a negedge, release, wander straps, settle final value before capture edge
    task automatic boot(input logic [5:0] final_strap);
        @(negedge clk_ref);
        rst_n = 1'b0;
        pad_in = 6'($urandom);
        #3;
        check_hold("R1 in reset");
        @(negedge clk_ref);
        rst_n = 1'b1;
        check_hold("R1 after release");
        for (int k = 0; k < int'(WAIT) - 1; k++) begin
            @(posedge clk_ref);
            @(negedge clk_ref);
            pad_in = 6'($urandom);
        end
        check("R2 oe before expiry", 32'(pad_oe), 32'h0);
        check("R2 done before expiry", 32'(cfg_done), 32'h0);
        pad_in = final_strap;
        @(posedge clk_ref);
        @(negedge clk_ref);
        check("R2 done at expiry", 32'(cfg_done), 32'h1);
        check("R5 oe all on", 32'(pad_oe), 32'h3F);
        check("R3 freq_sel", 32'(freq_sel), 32'(final_strap[4:0]));
        check("R3 rate_sel", 32'(rate_sel), 32'(final_strap[5]));
    endtask

    task automatic run_driving(input logic [5:0] strap, input int cycles);
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk_ref);
            pad_in  = 6'($urandom);
            clk_src = 6'($urandom);
            oe_mask = (k % 5 == 0) ? 6'h3F : 6'($urandom);
            #2;
            check("R6 pad_out", 32'(pad_out), 32'(exp_out(1'b1, clk_src, oe_mask)));
            check("R4 straps frozen", 32'({rate_sel, freq_sel}), 32'(strap));
            check("R5 done sticky", 32'({cfg_done, pad_oe}), 32'h7F);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [5:0] s;
        void'($urandom(32'd4242));
        #1;
        check_hold("R1 initial");
        s = 6'h00; boot(s); run_driving(s, 20);
        s = 6'h3F; boot(s); run_driving(s, 20);
        s = 6'h20; boot(s); run_driving(s, 10);
        s = 6'h1F; boot(s); run_driving(s, 10);
        for (int t = 0; t < 6; t++) begin
            s = 6'($urandom);
            boot(s);
            run_driving(s, 25);
        end

        // R6 hold state keeps pads low even with sources and mask active
        @(negedge clk_ref);
        rst_n = 1'b0;
        clk_src = 6'h3F;
        oe_mask = 6'h3F;
        @(negedge clk_ref);
        rst_n = 1'b1;
        @(posedge clk_ref);
        @(negedge clk_ref);
        check("R6 pads low in hold", 32'(pad_out), 32'(exp_out(1'b0, clk_src, oe_mask)));

        // R7 reset partway through the window restarts the count
        repeat (WAIT / 2) @(posedge clk_ref);
        #3;
        rst_n = 1'b0;
        #2;
        check("R7 done cleared", 32'(cfg_done), 32'h0);
        @(negedge clk_ref);
        rst_n = 1'b1;
        for (int k = 0; k < int'(WAIT) - 1; k++) @(negedge clk_ref);
        check("R7 not enabled at WAIT-1 after restart", 32'(cfg_done), 32'h0);
        pad_in = 6'h2A;
        @(negedge clk_ref);
        check("R7 enabled at WAIT after restart", 32'(cfg_done), 32'h1);
        check("R7 R3 capture after restart", 32'({rate_sel, freq_sel}), 32'h2A);

        finish_run();
    end
endmodule